// File: doc/BRIEF.md
# SAR Conversion Frame Timer

This block paces a successive-approximation converter. It counts reference ticks in a fixed frame and drives four registered waveforms from the frame position: a one-tick convert command, an asymmetric bit clock with one pulse for each sequencer stage, a frame-start marker for downstream logic, and an acquisition marker that shows when the sample/hold is tracking the input. The reference tick runs at 64 times the sample rate, so one frame is one sample period.

The reference tick is made from the block clock by a divider whose ratio is a parameter. When the clock already runs at the reference rate, the ratio is 1 and every clock is a tick. A run input starts and stops the frame sequence. While run is low, the block sits idle with every output low. The first tick after run is seen high is always the convert tick. All frame intervals are parameters counted in reference ticks.

Top module: `sar_frame_timer`

## Requirements
- R1: With the default parameters, a frame lasts 64 reference ticks. The convert command rises once per frame, and consecutive rises are 64 ticks apart.
- R2: The convert output is high for exactly one reference tick, at frame position 0, and low at every other position.
- R3: The frame-start output is high at frame position 0 only, on the same tick as convert.
- R4: The first bit-clock high tick of a frame is at position 4, that is 4 ticks after convert rises. The bit clock is low at positions 0 to 3.
- R5: The bit clock repeats every 3 ticks while active: high for 1 tick, then low for 2. High ticks fall at positions 4, 7, 10, and so on.
- R6: Exactly 19 bit-clock pulses occur in each frame. The last is high at position 58, and the bit clock stays low from position 59 through position 3 of the next frame.
- R7: The acquisition output covers 6 ticks: positions 59 to 63 and the convert tick at position 0. It is never high together with the bit clock.
- R8: While the synchronous reset is high, all four outputs are low. If run is high when reset is released, the first tick after release shows position 0, with convert, frame-start and acquisition high and the bit clock low.
- R9: If run is low at a clock edge, all outputs are low after that edge. When run is raised again, the first edge that sees it high restarts the frame at position 0.
- R10: With a divider ratio of D, each frame position lasts exactly D clock cycles, and the waveform sequence matches the one for a ratio of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock (reference clock times the divider ratio) |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Frame sequence enable; low holds the block idle |
| convert_o | output | 1 | Convert command, high on the first tick of each frame |
| bitclk_o | output | 1 | Bit clock, one high tick for each approximation stage |
| frame_start_o | output | 1 | Frame-start marker, one tick wide |
| acquire_o | output | 1 | High while the sample/hold is acquiring |

## Verification
The bench builds two copies of the block. One uses the default divider ratio of 1, so every clock is a reference tick and each frame position can be checked on its own cycle: the exact bit-clock positions, the 19-pulse count and the 64-tick convert spacing. The second copy uses a divider ratio of 4, which shows that every position is stretched to four cycles without shifting the waveform, and it lets the checker test its run-length windows with a ratio larger than one. Stopping the run and resetting in the middle of a frame are exercised on the first copy.

// File: rtl/sar_timer_pkg.sv
package sar_timer_pkg;

    // One frame-position decode: the four waveform levels for a position.
    typedef struct packed {
        logic convert;
        logic bitclk;
        logic frame_start;
        logic acquire;
    } wave_t;

    localparam wave_t WAVE_IDLE = '{convert: 1'b0, bitclk: 1'b0,
                                    frame_start: 1'b0, acquire: 1'b0};

endpackage

// File: rtl/sar_ref_tick_div.sv
// Divides the block clock down to the reference tick rate.
module sar_ref_tick_div #(
    parameter int unsigned REF_DIV = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    // The idle value is the last count, so the first run edge is a tick.
    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt == CNT_LAST);
        if (!run_i) begin
            st_d.cnt = CNT_LAST;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt <= CNT_LAST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sar_frame_pos.sv
// Frame position counter; exposes the next position so the outputs can be
// registered against the position they describe.
module sar_frame_pos #(
    parameter int unsigned FRAME_TICKS = 64,
    localparam int unsigned POS_W = $clog2(FRAME_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_next_o
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_TICKS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pos_state_t;

    pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.pos = POS_LAST;
        end else if (tick_i) begin
            st_d.pos = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
        end
        pos_next_o = st_d.pos;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pos <= POS_LAST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sar_wave_decode.sv
// Combinational map from frame position to waveform levels.
module sar_wave_decode
    import sar_timer_pkg::*;
#(
    parameter int unsigned FRAME_TICKS = 64,
    parameter int unsigned CONV_TICKS  = 1,
    parameter int unsigned CONV_TO_CLK = 4,
    parameter int unsigned CLK_HI      = 1,
    parameter int unsigned CLK_LO      = 2,
    parameter int unsigned N_BITS      = 19,
    parameter int unsigned ACQ_TICKS   = 6,
    localparam int unsigned POS_W = $clog2(FRAME_TICKS)
) (
    input  logic [POS_W-1:0] pos_i,
    output wave_t            wave_o
);
    localparam int CLK_PER   = int'(CLK_HI + CLK_LO);
    localparam int WIN_FIRST = int'(CONV_TO_CLK);
    localparam int WIN_END   = WIN_FIRST + CLK_PER * int'(N_BITS);
    localparam int ACQ_FIRST = int'(FRAME_TICKS) - int'(ACQ_TICKS - CONV_TICKS);

    int  p;
    int  phase;
    logic in_window;

    always_comb begin
        p         = int'(pos_i);
        in_window = (p >= WIN_FIRST) && (p < WIN_END);
        phase     = in_window ? (p - WIN_FIRST) % CLK_PER : 0;

        wave_o             = WAVE_IDLE;
        wave_o.convert     = (p < int'(CONV_TICKS));
        wave_o.frame_start = (p == 0);
        wave_o.bitclk      = in_window && (phase < int'(CLK_HI));
        wave_o.acquire     = (p < int'(CONV_TICKS)) || (p >= ACQ_FIRST);
    end
endmodule

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
    import sar_timer_pkg::*;
#(
    parameter int unsigned FRAME_TICKS = 64,
    parameter int unsigned CONV_TICKS  = 1,
    parameter int unsigned CONV_TO_CLK = 4,
    parameter int unsigned CLK_HI      = 1,
    parameter int unsigned CLK_LO      = 2,
    parameter int unsigned N_BITS      = 19,
    parameter int unsigned ACQ_TICKS   = 6,
    parameter int unsigned REF_DIV     = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic convert_o,
    output logic bitclk_o,
    output logic frame_start_o,
    output logic acquire_o
);
    localparam int unsigned POS_W    = $clog2(FRAME_TICKS);
    localparam int unsigned CLK_PER  = CLK_HI + CLK_LO;
    localparam int unsigned LAST_HI  = CONV_TO_CLK + CLK_PER * (N_BITS - 1) + CLK_HI;
    localparam int unsigned ACQ_FROM = FRAME_TICKS - (ACQ_TICKS - CONV_TICKS);

    // Elaboration-time consistency of the frame layout.
    generate
        if (CONV_TO_CLK < CONV_TICKS) begin : g_bad_gap
            $error("bit clock would overlap convert");
        end
        if (LAST_HI > ACQ_FROM) begin : g_bad_fit
            $error("bit clocks run into the acquisition window");
        end
        if (ACQ_TICKS < CONV_TICKS || REF_DIV < 1) begin : g_bad_param
            $error("invalid acquisition length or divider ratio");
        end
    endgenerate

    logic             tick;
    logic [POS_W-1:0] pos_next;
    wave_t            wave_dec;

    typedef struct packed {
        wave_t wave;
    } out_state_t;

    out_state_t st_d, st_q;

    sar_ref_tick_div #(
        .REF_DIV (REF_DIV)
    ) div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run_i),
        .tick_o (tick)
    );

    sar_frame_pos #(
        .FRAME_TICKS (FRAME_TICKS)
    ) pos_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (run_i),
        .tick_i     (tick),
        .pos_next_o (pos_next)
    );

    sar_wave_decode #(
        .FRAME_TICKS (FRAME_TICKS),
        .CONV_TICKS  (CONV_TICKS),
        .CONV_TO_CLK (CONV_TO_CLK),
        .CLK_HI      (CLK_HI),
        .CLK_LO      (CLK_LO),
        .N_BITS      (N_BITS),
        .ACQ_TICKS   (ACQ_TICKS)
    ) dec_i (
        .pos_i  (pos_next),
        .wave_o (wave_dec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wave = run_i ? wave_dec : WAVE_IDLE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.wave <= WAVE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign convert_o     = st_q.wave.convert;
    assign bitclk_o      = st_q.wave.bitclk;
    assign frame_start_o = st_q.wave.frame_start;
    assign acquire_o     = st_q.wave.acquire;
endmodule

// File: rtl/sar_timer_chk.sv
module sar_timer_chk #(
    parameter int unsigned CONV_TICKS = 1,
    parameter int unsigned CLK_HI     = 1,
    parameter int unsigned REF_DIV    = 1
) (
    input logic clk_i,
    input logic rst_i,
    input logic run_i,
    input logic convert_o,
    input logic bitclk_o,
    input logic frame_start_o,
    input logic acquire_o
);
    localparam int unsigned CONV_CYC = CONV_TICKS * REF_DIV;
    localparam int unsigned BCLK_CYC = CLK_HI * REF_DIV;

    logic [15:0] conv_run_q;
    logic [15:0] bclk_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            conv_run_q <= '0;
            bclk_run_q <= '0;
        end else begin
            conv_run_q <= convert_o ? conv_run_q + 16'd1 : 16'd0;
            bclk_run_q <= bitclk_o  ? bclk_run_q + 16'd1 : 16'd0;
        end
    end

    // R3
    sof_with_conv_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |-> convert_o);

    // R2
    conv_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        convert_o |-> (conv_run_q < 16'(CONV_CYC)));

    // R5
    bclk_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bitclk_o |-> (bclk_run_q < 16'(BCLK_CYC)));

    // R7
    acq_no_bclk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        acquire_o |-> !bitclk_o);

    // R4
    conv_no_bclk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        convert_o |-> !bitclk_o);

    // R9
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (!convert_o && !bitclk_o && !frame_start_o && !acquire_o));
endmodule

bind sar_frame_timer sar_timer_chk #(
    .CONV_TICKS (CONV_TICKS),
    .CLK_HI     (CLK_HI),
    .REF_DIV    (REF_DIV)
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .run_i         (run_i),
    .convert_o     (convert_o),
    .bitclk_o      (bitclk_o),
    .frame_start_o (frame_start_o),
    .acquire_o     (acquire_o)
);

// File: tb/sar_frame_timer_tb_top.sv
module sar_frame_timer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run1 = 1'b0;
    logic run4 = 1'b0;
    logic conv1, bclk1, sof1, acq1;
    logic conv4, bclk4, sof4, acq4;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sar_frame_timer dut_i (
        .clk_i (clk), .rst_i (rst), .run_i (run1),
        .convert_o (conv1), .bitclk_o (bclk1),
        .frame_start_o (sof1), .acquire_o (acq1)
    );

    sar_frame_timer #(.REF_DIV(4)) dut_div_i (
        .clk_i (clk), .rst_i (rst), .run_i (run4),
        .convert_o (conv4), .bitclk_o (bclk4),
        .frame_start_o (sof4), .acquire_o (acq4)
    );

    // Expected {convert, bitclk, frame_start, acquire} at a frame position.
    function automatic logic [3:0] model(input int p);
        logic c, b, s, a;
        c = (p == 0);
        s = (p == 0);
        b = (p >= 4) && (p <= 58) && ((p - 4) % 3 == 0);
        a = (p == 0) || (p >= 59);
        return {c, b, s, a};
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs(input bit div4);
        return div4 ? {conv4, bclk4, sof4, acq4} : {conv1, bclk1, sof1, acq1};
    endfunction

    // Compare every output per sample; sample k shows position (k/div)%64.
    task automatic scan(input bit div4, input int nsamp, input int first_pos);
        int div = div4 ? 4 : 1;
        for (int k = 0; k < nsamp; k++) begin
            logic [3:0] e, a;
            int p;
            @(negedge clk);
            p = (first_pos + k / div) % 64;
            e = model(p);
            a = outs(div4);
            chk(a[3] == e[3], div4 ? "R10 convert" : "R2 convert", a[3], e[3]);
            chk(a[2] == e[2], div4 ? "R10 bitclk" : "R5 bitclk", a[2], e[2]);
            chk(a[1] == e[1], div4 ? "R10 frame_start" : "R3 frame_start", a[1], e[1]);
            chk(a[0] == e[0], div4 ? "R10 acquire" : "R7 acquire", a[0], e[0]);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; run1 = 1'b1;
        repeat (3) @(negedge clk);
        chk({conv1, bclk1, sof1, acq1} == 4'b0, "R8 reset idle", {conv1, bclk1, sof1, acq1}, 0);
        chk({conv4, bclk4, sof4, acq4} == 4'b0, "R8 reset idle div", {conv4, bclk4, sof4, acq4}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({conv1, bclk1, sof1, acq1} == 4'b1011, "R8 first tick", {conv1, bclk1, sof1, acq1}, 11);
        scan(1'b0, 63, 1);
    endtask

    // Counts pulses and convert spacing over two frames.
    task automatic t_frames;
        int first_bclk = -1;
        int pulses0 = 0, pulses1 = 0;
        int conv_rise[2];
        int nrise = 0;
        logic pb = 1'b0, pc = 1'b0;
        // Now at the negedge showing position 63; next samples start at 0.
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            if (bclk1 && !pb) begin
                if (k < 64) pulses0++; else pulses1++;
                if (first_bclk < 0) first_bclk = k;
            end
            if (conv1 && !pc && nrise < 2) begin
                conv_rise[nrise] = k;
                nrise++;
            end
            if (k == 58) chk(bclk1 == 1'b1, "R6 last pulse", bclk1, 1);
            if (k >= 59 && k <= 67) chk(bclk1 == 1'b0, "R6 tail low", bclk1, 0);
            pb = bclk1; pc = conv1;
        end
        chk(first_bclk == 4, "R4 first bit clock", first_bclk, 4);
        chk(pulses0 == 19, "R6 pulses frame 0", pulses0, 19);
        chk(pulses1 == 19, "R6 pulses frame 1", pulses1, 19);
        chk(nrise == 2, "R1 convert rises", nrise, 2);
        if (nrise == 2)
            chk(conv_rise[1] - conv_rise[0] == 64, "R1 frame length",
                conv_rise[1] - conv_rise[0], 64);
    endtask

    task automatic t_stop_restart;
        // After t_frames the last sample shows position 63.
        scan(1'b0, 21, 0);
        run1 = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk({conv1, bclk1, sof1, acq1} == 4'b0, "R9 stopped idle",
                {conv1, bclk1, sof1, acq1}, 0);
        end
        run1 = 1'b1;
        scan(1'b0, 8, 0);
    endtask

    task automatic t_mid_reset;
        scan(1'b0, 30, 8);
        rst = 1'b1;
        @(negedge clk);
        chk({conv1, bclk1, sof1, acq1} == 4'b0, "R8 mid reset idle",
            {conv1, bclk1, sof1, acq1}, 0);
        chk({conv4, bclk4, sof4, acq4} == 4'b0, "R8 mid reset idle div",
            {conv4, bclk4, sof4, acq4}, 0);
        rst = 1'b0;
        scan(1'b0, 10, 0);
    endtask

    task automatic t_divider;
        int conv_len = 0;
        run4 = 1'b1;
        scan(1'b1, 4, 0);
        // Re-enter from idle to measure convert length in clocks.
        run4 = 1'b0;
        @(negedge clk);
        run4 = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (conv4) conv_len++;
        end
        chk(conv_len == 4, "R10 convert length", conv_len, 4);
        scan(1'b1, 64 * 4 - 8, 2);
        scan(1'b1, 8, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_frames();
        t_stop_restart();
        t_mid_reset();
        t_divider();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule